// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel

This block is one DMA channel that follows a linked run of 8-byte descriptors stored in memory and moves the data that each one points at. Software gives the channel the address of the first descriptor through a small register port. The channel then reads descriptors one after another over a 32-bit memory read port. For each descriptor it moves whole 32-bit words between a memory buffer and a streaming device port that uses valid/ready handshaking. It stops after the descriptor flagged as the end of the chain and records completion in a status register that can drive an interrupt line.

An elaboration parameter sets the direction. In transmit form, words are read from memory and sent out on the stream port, and the channel starts as soon as the low descriptor pointer is written. In receive form, words taken from the stream port are written to memory, and the channel starts and stops through a separate run register.

A descriptor sits at an 8-byte-aligned address P and is read as two little-endian words. The word at P carries the flags in bits 7:0, a reserved byte in bits 15:8 and the byte length in bits 31:16. The word at P+4 is the buffer address.

Top module: `dmach_top`

## Requirements
- R1: After reset, `busy`, `irq`, all memory requests, `tx_valid` and `rx_ready` are low, and the status register (offset 0x20) reads 0.
- R2: A descriptor at address P is fetched as a read of P followed by a read of P+4. Flag bit 0 means valid, flag bit 1 means last, and flag bit 5 (transfer) needs no action. Length is word0[31:16]. Buffer address is word1.
- R3: Offset 0x00 stores the upper pointer word and reads it back. Offset 0x04 stores the lower pointer with bits 2:0 forced to zero. In transmit form, a write to 0x04 while idle starts the chain at that pointer.
- R4: For each descriptor, length/4 words (the low two length bits are ignored) move in rising address order, starting at the buffer address with bits 1:0 cleared.
- R5: Descriptors are taken at P, P+8, P+16 and so on until the descriptor with the last flag has been fully moved.
- R6: A valid descriptor whose length is below 4 moves no data. The channel goes straight on to the next descriptor, or completes if that descriptor is last.
- R7: A descriptor read with the valid flag clear stops the channel, sets status bit 1 (error) and moves no data for that descriptor.
- R8: Completing a chain sets status bit 0 (done). Writing 1 to a status bit clears it. Status bit 2 reads the busy state.
- R9: `irq` is high exactly when (status[1:0] AND enable[1:0]) is non-zero, where the enable register is at offset 0x24. Offset 0x28 reads that masked value.
- R10: `busy` is high from the start until the chain ends (the last word accepted, an error, or a stop). While busy, a write that would start the channel, and any write to 0x04, is ignored.
- R11: In receive form, writing 1 to bit 0 of offset 0x14 while idle starts the chain at the stored pointer. Writing 0 there while busy stops the channel without setting done. A write to 0x04 alone does not start it. The run bit reads back as 0 once the chain ends.
- R12: A memory request keeps its address (and write data) until it is acknowledged. Stream data is held stable while `tx_valid` is high and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_ack | input | 1 | Read acknowledge; `mem_rd_data` is valid in the same cycle |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_wr_req | output | 1 | Memory write request (receive form) |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| tx_valid | output | 1 | Outgoing stream word valid |
| tx_data | output | DATA_W | Outgoing stream word |
| tx_ready | input | 1 | Outgoing stream ready |
| rx_valid | input | 1 | Incoming stream word valid |
| rx_data | input | DATA_W | Incoming stream word |
| rx_ready | output | 1 | Incoming stream ready |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | Masked completion/error interrupt |

## Verification
Transmit chains of one to three descriptors are swept over rotating word counts. The set includes zero-length entries and lengths that are not a multiple of four, under random stream back-pressure and memory stalls. Comparing the captured stream with words taken from the bench memory model shows whether ordering, chain stepping, skipping and length truncation are right. Separate patterns cover an invalid descriptor (alone and after a good one) to tell error from done, a start attempt while busy to tell an ignored write from a restart, and receive chains with a mid-transfer stop that must end the run without a done flag.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   localparam int DESC_BYTES = 8;
   localparam int FLG_VALID  = 0;
   localparam int FLG_LAST   = 1;
   localparam int FLG_XFER   = 5;

   localparam int OFS_PTR_HI = 'h00;
   localparam int OFS_PTR_LO = 'h04;
   localparam int OFS_RUN    = 'h14;
   localparam int OFS_STAT   = 'h20;
   localparam int OFS_IEN    = 'h24;
   localparam int OFS_PEND   = 'h28;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FETCH_LO,
      SQ_FETCH_HI,
      SQ_DECODE,
      SQ_MOVE
   } seq_state_t;

   typedef enum logic [1:0] {
      MV_IDLE,
      MV_MEM,
      MV_STRM
   } mv_state_t;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
   import dmach_pkg::*;
#(
   parameter int REG_AW  = 8,
   parameter int ADDR_W  = 32,
   parameter bit RX_MODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rd_data_o,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic              err_i,
   output logic              start_o,
   output logic              stop_o,
   output logic [ADDR_W-1:0] base_o,
   output logic              irq_o
);
   localparam logic [REG_AW-1:0] A_HI   = REG_AW'(OFS_PTR_HI);
   localparam logic [REG_AW-1:0] A_LO   = REG_AW'(OFS_PTR_LO);
   localparam logic [REG_AW-1:0] A_RUN  = REG_AW'(OFS_RUN);
   localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
   localparam logic [REG_AW-1:0] A_IEN  = REG_AW'(OFS_IEN);
   localparam logic [REG_AW-1:0] A_PEND = REG_AW'(OFS_PEND);

   logic [31:0]       ptr_hi_q;
   logic [ADDR_W-1:0] ptr_lo_q;
   logic [1:0]        stat_q;
   logic [1:0]        ien_q;
   logic              run_q;
   logic              hit_hi, hit_lo, hit_run, hit_stat, hit_ien;
   logic [ADDR_W-1:0] wr_ptr;
   logic [1:0]        clr_bits;

   assign hit_hi   = wr_en_i && (addr_i == A_HI);
   assign hit_lo   = wr_en_i && (addr_i == A_LO);
   assign hit_run  = wr_en_i && (addr_i == A_RUN);
   assign hit_stat = wr_en_i && (addr_i == A_STAT);
   assign hit_ien  = wr_en_i && (addr_i == A_IEN);
   assign wr_ptr   = {wdata_i[ADDR_W-1:3], 3'b000};
   assign clr_bits = hit_stat ? wdata_i[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_hi_q <= '0;
         ptr_lo_q <= '0;
         stat_q   <= '0;
         ien_q    <= '0;
      end else begin
         if (hit_hi) ptr_hi_q <= wdata_i;
         if (hit_lo && !busy_i) ptr_lo_q <= wr_ptr;
         if (hit_ien) ien_q <= wdata_i[1:0];
         // a new event wins over a clear in the same cycle
         stat_q <= (stat_q & ~clr_bits) | {err_i, done_i};
      end
   end

   generate
      if (RX_MODE) begin : g_rx_start
         assign start_o = hit_run && wdata_i[0] && !busy_i;
         assign stop_o  = hit_run && !wdata_i[0] && busy_i;
         assign base_o  = ptr_lo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= 1'b0;
            end else if (start_o) begin
               run_q <= 1'b1;
            end else if (hit_run || done_i || err_i) begin
               run_q <= 1'b0;
            end
         end
      end else begin : g_tx_start
         assign start_o = hit_lo && !busy_i;
         assign stop_o  = 1'b0;
         assign base_o  = wr_ptr;
         assign run_q   = 1'b0;
      end
   endgenerate

   assign irq_o = |(stat_q & ien_q);

   always_comb begin
      rd_data_o = '0;
      if (addr_i == A_HI)        rd_data_o = ptr_hi_q;
      else if (addr_i == A_LO)   rd_data_o = 32'(ptr_lo_q);
      else if (addr_i == A_RUN)  rd_data_o = {31'b0, run_q};
      else if (addr_i == A_STAT) rd_data_o = {29'b0, busy_i, stat_q};
      else if (addr_i == A_IEN)  rd_data_o = {30'b0, ien_q};
      else if (addr_i == A_PEND) rd_data_o = {30'b0, stat_q & ien_q};
   end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
   import dmach_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   localparam int WC_W  = LEN_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              f_req_o,
   output logic [ADDR_W-1:0] f_addr_o,
   input  logic              f_ack_i,
   input  logic [DATA_W-1:0] f_data_i,
   output logic              mv_start_o,
   output logic [ADDR_W-1:0] mv_addr_o,
   output logic [WC_W-1:0]   mv_words_o,
   input  logic              mv_done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              abort_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);
   localparam logic [ADDR_W-1:0] HALF = ADDR_W'(DESC_BYTES / 2);

   seq_state_t        st_q, st_d;
   logic [ADDR_W-1:0] ptr_q, ptr_d;
   logic [DATA_W-1:0] w0_q, w1_q;
   logic [7:0]        flags;
   logic [LEN_W-1:0]  len;
   logic [WC_W-1:0]   words;
   logic              is_last, is_valid;

   assign flags    = w0_q[7:0];
   assign len      = w0_q[16 +: LEN_W];
   assign words    = len[LEN_W-1:2];
   assign is_last  = flags[FLG_LAST];
   assign is_valid = flags[FLG_VALID];

   assign busy_o     = (st_q != SQ_IDLE);
   assign abort_o    = stop_i && busy_o;
   assign f_req_o    = (st_q == SQ_FETCH_LO) || (st_q == SQ_FETCH_HI);
   assign f_addr_o   = (st_q == SQ_FETCH_HI) ? ptr_q + HALF : ptr_q;
   assign mv_addr_o  = w1_q[ADDR_W-1:0];
   assign mv_words_o = words;

   always_comb begin
      st_d       = st_q;
      ptr_d      = ptr_q;
      mv_start_o = 1'b0;
      done_o     = 1'b0;
      err_o      = 1'b0;
      if (abort_o) begin
         st_d = SQ_IDLE;
      end else begin
         case (st_q)
            SQ_IDLE: if (start_i) begin
               ptr_d = base_i;
               st_d  = SQ_FETCH_LO;
            end
            SQ_FETCH_LO: if (f_ack_i) st_d = SQ_FETCH_HI;
            SQ_FETCH_HI: if (f_ack_i) st_d = SQ_DECODE;
            SQ_DECODE: begin
               if (!is_valid) begin
                  err_o = 1'b1;
                  st_d  = SQ_IDLE;
               end else if (words == '0) begin
                  if (is_last) begin
                     done_o = 1'b1;
                     st_d   = SQ_IDLE;
                  end else begin
                     ptr_d = ptr_q + STEP;
                     st_d  = SQ_FETCH_LO;
                  end
               end else begin
                  mv_start_o = 1'b1;
                  st_d       = SQ_MOVE;
               end
            end
            SQ_MOVE: if (mv_done_i) begin
               if (is_last) begin
                  done_o = 1'b1;
                  st_d   = SQ_IDLE;
               end else begin
                  ptr_d = ptr_q + STEP;
                  st_d  = SQ_FETCH_LO;
               end
            end
            default: st_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         ptr_q <= '0;
         w0_q  <= '0;
         w1_q  <= '0;
      end else begin
         st_q  <= st_d;
         ptr_q <= ptr_d;
         if (st_q == SQ_FETCH_LO && f_ack_i) w0_q <= f_data_i;
         if (st_q == SQ_FETCH_HI && f_ack_i) w1_q <= f_data_i;
      end
   end
endmodule

// File: rtl/dmach_mover.sv
module dmach_mover
   import dmach_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 16,
   parameter bit RX_MODE = 1'b0,
   localparam int WC_W   = LEN_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WC_W-1:0]   words_i,
   output logic              done_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_ack_i,
   output logic              tx_valid_o,
   output logic [DATA_W-1:0] tx_data_o,
   input  logic              tx_ready_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_data_i,
   output logic              rx_ready_o
);
   localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(DATA_W / 8);
   localparam logic [WC_W-1:0]   ONE   = WC_W'(1);

   mv_state_t         st_q;
   logic [WC_W-1:0]   cnt_q;
   logic [ADDR_W-1:0] ad_q;
   logic [DATA_W-1:0] hold_q;
   logic [ADDR_W-1:0] first_ad;

   assign first_ad = {addr_i[ADDR_W-1:2], 2'b00};

   generate
      if (RX_MODE) begin : g_rx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q   <= MV_IDLE;
               cnt_q  <= '0;
               ad_q   <= '0;
               hold_q <= '0;
            end else if (abort_i) begin
               st_q <= MV_IDLE;
            end else begin
               case (st_q)
                  MV_IDLE: if (start_i) begin
                     ad_q  <= first_ad;
                     cnt_q <= words_i;
                     st_q  <= MV_STRM;
                  end
                  MV_STRM: if (rx_valid_i) begin
                     hold_q <= rx_data_i;
                     st_q   <= MV_MEM;
                  end
                  MV_MEM: if (wr_ack_i) begin
                     if (cnt_q == ONE) begin
                        st_q <= MV_IDLE;
                     end else begin
                        cnt_q <= cnt_q - ONE;
                        ad_q  <= ad_q + WSTEP;
                        st_q  <= MV_STRM;
                     end
                  end
                  default: st_q <= MV_IDLE;
               endcase
            end
         end
         assign rx_ready_o = (st_q == MV_STRM);
         assign wr_req_o   = (st_q == MV_MEM);
         assign wr_addr_o  = ad_q;
         assign wr_data_o  = hold_q;
         assign done_o     = (st_q == MV_MEM) && wr_ack_i && (cnt_q == ONE);
         assign rd_req_o   = 1'b0;
         assign rd_addr_o  = '0;
         assign tx_valid_o = 1'b0;
         assign tx_data_o  = '0;
      end else begin : g_tx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q   <= MV_IDLE;
               cnt_q  <= '0;
               ad_q   <= '0;
               hold_q <= '0;
            end else if (abort_i) begin
               st_q <= MV_IDLE;
            end else begin
               case (st_q)
                  MV_IDLE: if (start_i) begin
                     ad_q  <= first_ad;
                     cnt_q <= words_i;
                     st_q  <= MV_MEM;
                  end
                  MV_MEM: if (rd_ack_i) begin
                     hold_q <= rd_data_i;
                     st_q   <= MV_STRM;
                  end
                  MV_STRM: if (tx_ready_i) begin
                     if (cnt_q == ONE) begin
                        st_q <= MV_IDLE;
                     end else begin
                        cnt_q <= cnt_q - ONE;
                        ad_q  <= ad_q + WSTEP;
                        st_q  <= MV_MEM;
                     end
                  end
                  default: st_q <= MV_IDLE;
               endcase
            end
         end
         assign rd_req_o   = (st_q == MV_MEM);
         assign rd_addr_o  = ad_q;
         assign tx_valid_o = (st_q == MV_STRM);
         assign tx_data_o  = hold_q;
         assign done_o     = (st_q == MV_STRM) && tx_ready_i && (cnt_q == ONE);
         assign rx_ready_o = 1'b0;
         assign wr_req_o   = 1'b0;
         assign wr_addr_o  = '0;
         assign wr_data_o  = '0;
      end
   endgenerate
endmodule

// File: rtl/dmach_top.sv
module dmach_top
   import dmach_pkg::*;
#(
   parameter bit RX_MODE = 1'b0,
   parameter int REG_AW  = 8,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rd_data,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              busy,
   output logic              irq
);
   localparam int WC_W = LEN_W - 2;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dmach_top: DATA_W must be 32");
   end
   if (ADDR_W != 32) begin : g_bad_addr_w
      $error("dmach_top: ADDR_W must be 32");
   end
   if (LEN_W < 3 || LEN_W > 16) begin : g_bad_len_w
      $error("dmach_top: LEN_W must be within 3..16");
   end
   if (REG_AW < 6) begin : g_bad_reg_aw
      $error("dmach_top: REG_AW must reach offset 0x28");
   end

   logic              start_p, stop_p, done_p, err_p, abort_p;
   logic [ADDR_W-1:0] base_w;
   logic              seq_f_req, seq_f_ack;
   logic [ADDR_W-1:0] seq_f_addr;
   logic              mv_start, mv_done, mv_rd_req, mv_rd_ack;
   logic [ADDR_W-1:0] mv_addr, mv_rd_addr;
   logic [WC_W-1:0]   mv_words;

   dmach_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .RX_MODE(RX_MODE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (reg_wr_en),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .rd_data_o (reg_rd_data),
      .busy_i    (busy),
      .done_i    (done_p),
      .err_i     (err_p),
      .start_o   (start_p),
      .stop_o    (stop_p),
      .base_o    (base_w),
      .irq_o     (irq)
   );

   dmach_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_p),
      .stop_i     (stop_p),
      .base_i     (base_w),
      .f_req_o    (seq_f_req),
      .f_addr_o   (seq_f_addr),
      .f_ack_i    (seq_f_ack),
      .f_data_i   (mem_rd_data),
      .mv_start_o (mv_start),
      .mv_addr_o  (mv_addr),
      .mv_words_o (mv_words),
      .mv_done_i  (mv_done),
      .busy_o     (busy),
      .done_o     (done_p),
      .err_o      (err_p),
      .abort_o    (abort_p)
   );

   dmach_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                 .RX_MODE(RX_MODE)) u_mover (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (mv_start),
      .abort_i    (abort_p),
      .addr_i     (mv_addr),
      .words_i    (mv_words),
      .done_o     (mv_done),
      .rd_req_o   (mv_rd_req),
      .rd_addr_o  (mv_rd_addr),
      .rd_ack_i   (mv_rd_ack),
      .rd_data_i  (mem_rd_data),
      .wr_req_o   (mem_wr_req),
      .wr_addr_o  (mem_wr_addr),
      .wr_data_o  (mem_wr_data),
      .wr_ack_i   (mem_wr_ack),
      .tx_valid_o (tx_valid),
      .tx_data_o  (tx_data),
      .tx_ready_i (tx_ready),
      .rx_valid_i (rx_valid),
      .rx_data_i  (rx_data),
      .rx_ready_o (rx_ready)
   );

   // read port shared: the sequencer and the mover never request together
   assign mem_rd_req  = seq_f_req | mv_rd_req;
   assign mem_rd_addr = seq_f_req ? seq_f_addr : mv_rd_addr;
   assign seq_f_ack   = mem_rd_ack & seq_f_req;
   assign mv_rd_ack   = mem_rd_ack & mv_rd_req;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              stop,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ack,
   input logic              mem_wr_req,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic              mem_wr_ack,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_ready,
   input logic              seq_rd,
   input logic              mv_rd
);
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack && !stop) |=> (mem_rd_req && $stable(mem_rd_addr))); // R12
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack && !stop) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R12
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_req && !mem_wr_req && !tx_valid)); // R10
   AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_rd && mv_rd)); // R2
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00)); // R4
endmodule

bind dmach_top dmach_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .stop        (stop_p),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_addr (mem_rd_addr),
   .mem_rd_ack  (mem_rd_ack),
   .mem_wr_req  (mem_wr_req),
   .mem_wr_addr (mem_wr_addr),
   .mem_wr_data (mem_wr_data),
   .mem_wr_ack  (mem_wr_ack),
   .tx_valid    (tx_valid),
   .tx_data     (tx_data),
   .tx_ready    (tx_ready),
   .seq_rd      (seq_f_req),
   .mv_rd       (mv_rd_req)
);

// File: tb/dmach_top_tb.sv
module dmach_top_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;
   logic rst_n = 1'b0;

   logic [31:0] mem [0:1023];
   logic [7:0]  lfsr = 8'h5B;
   logic        stall = 1'b0;
   logic        hold_ready = 1'b0;
   logic        rx_gen = 1'b0;
   int          rx_idx = 0;
   logic [31:0] cap [0:255];
   logic [31:0] expv [0:255];
   int          cap_n = 0;
   int          exp_n = 0;
   int          n_chk = 0;
   int          n_bad = 0;

   // transmit instance
   logic        t_wen = 0;
   logic [7:0]  t_addr = 0;
   logic [31:0] t_wdata = 0, t_rdata;
   logic        t_rd_req, t_rd_ack, t_wr_req, t_wr_ack, t_valid, t_ready = 0;
   logic [31:0] t_rd_addr, t_rd_data, t_wr_addr, t_wr_data, t_data;
   logic        t_rxr, t_busy, t_irq;
   // receive instance
   logic        r_wen = 0;
   logic [7:0]  r_addr = 0;
   logic [31:0] r_wdata = 0, r_rdata;
   logic        r_rd_req, r_rd_ack, r_wr_req, r_wr_ack, r_txv;
   logic [31:0] r_rd_addr, r_rd_data, r_wr_addr, r_wr_data, r_txd;
   logic        r_valid = 0, r_ready, r_busy, r_irq;
   logic [31:0] r_data = 0;

   dmach_top #(.RX_MODE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(t_wen), .reg_addr(t_addr),
      .reg_wdata(t_wdata), .reg_rd_data(t_rdata),
      .mem_rd_req(t_rd_req), .mem_rd_addr(t_rd_addr), .mem_rd_ack(t_rd_ack),
      .mem_rd_data(t_rd_data), .mem_wr_req(t_wr_req), .mem_wr_addr(t_wr_addr),
      .mem_wr_data(t_wr_data), .mem_wr_ack(t_wr_ack),
      .tx_valid(t_valid), .tx_data(t_data), .tx_ready(t_ready),
      .rx_valid(1'b0), .rx_data(32'h0), .rx_ready(t_rxr),
      .busy(t_busy), .irq(t_irq));

   dmach_top #(.RX_MODE(1'b1)) u_dut_rx (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(r_wen), .reg_addr(r_addr),
      .reg_wdata(r_wdata), .reg_rd_data(r_rdata),
      .mem_rd_req(r_rd_req), .mem_rd_addr(r_rd_addr), .mem_rd_ack(r_rd_ack),
      .mem_rd_data(r_rd_data), .mem_wr_req(r_wr_req), .mem_wr_addr(r_wr_addr),
      .mem_wr_data(r_wr_data), .mem_wr_ack(r_wr_ack),
      .tx_valid(r_txv), .tx_data(r_txd), .tx_ready(1'b0),
      .rx_valid(r_valid), .rx_data(r_data), .rx_ready(r_ready),
      .busy(r_busy), .irq(r_irq));

   // memory model with random stalls
   assign t_rd_ack  = t_rd_req && !stall;
   assign t_rd_data = mem[t_rd_addr[11:2]];
   assign t_wr_ack  = t_wr_req && !stall;
   assign r_rd_ack  = r_rd_req && !stall;
   assign r_rd_data = mem[r_rd_addr[11:2]];
   assign r_wr_ack  = r_wr_req && !stall;

   always @(posedge clk) begin
      if (r_wr_req && r_wr_ack) mem[r_wr_addr[11:2]] <= r_wr_data;
   end

   // stimulus and capture away from the rising edge
   always @(negedge clk) begin
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      t_ready = !hold_ready && (lfsr[0] | lfsr[2]);
      stall   = lfsr[1] & lfsr[4];
      r_valid = rx_gen && (lfsr[3] | lfsr[5]);
      r_data  = 32'hC0DE0000 + 32'(rx_idx);
      #1;
      if (t_valid && t_ready && cap_n < 256) begin
         cap[cap_n] = t_data;
         cap_n++;
      end
      if (r_valid && r_ready) rx_idx++;
   end

   function automatic logic [31:0] fill(input int i);
      return 32'hA5000000 ^ (32'(i) * 32'h00010203);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input bit rx, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      if (rx) begin r_wen = 1; r_addr = a; r_wdata = d; end
      else    begin t_wen = 1; t_addr = a; t_wdata = d; end
      @(negedge clk);
      r_wen = 0;
      t_wen = 0;
   endtask

   task automatic reg_rd(input bit rx, input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      if (rx) r_addr = a; else t_addr = a;
      #1;
      d = rx ? r_rdata : t_rdata;
   endtask

   task automatic wait_idle(input bit rx);
      int n;
      n = 0;
      while ((rx ? r_busy : t_busy) && n < 4000) begin
         @(negedge clk);
         n++;
      end
      #2;
      if (n >= 4000) chk(1'b0, "R10 channel never went idle", 32'(n), 0);
   endtask

   task automatic put_desc(input int p, input logic [7:0] fl, input int len,
                           input logic [31:0] ad);
      mem[p >> 2]       = {16'(len), 8'h00, fl};
      mem[(p >> 2) + 1] = ad;
   endtask

   task automatic compare_cap(input string tag);
      bit ok;
      ok = (cap_n == exp_n);
      chk(ok, {tag, " word count"}, 32'(cap_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < cap_n; i++) begin
         if (cap[i] !== expv[i]) begin
            chk(1'b0, {tag, " word value"}, cap[i], expv[i]);
            break;
         end
      end
   endtask

   // build a chain at (wval & ~7), start it and compare
   task automatic tx_chain(input int n, input int s, input int wval);
      int base, len, ad;
      logic [31:0] st;
      base  = wval & ~7;
      exp_n = 0;
      for (int k = 0; k < n; k++) begin
         len = ((s + k) % 4) * 16 + ((s == 3) ? 2 : 0);
         ad  = 'h400 + k * 'h80;
         put_desc(base + 8 * k, (k == n - 1) ? 8'h23 : 8'h21, len, 32'(ad));
         for (int j = 0; j < len / 4; j++) begin
            expv[exp_n] = mem[(ad >> 2) + j];
            exp_n++;
         end
      end
      cap_n = 0;
      reg_wr(0, 8'h04, 32'(wval));
      wait_idle(0);
      compare_cap($sformatf("R4 R5 R6 R12 chain n=%0d s=%0d", n, s));
      reg_rd(0, 8'h20, st);
      chk(st == 32'h1, "R8 done bit after chain", st, 32'h1);
      reg_wr(0, 8'h20, 32'h3);
   endtask

   logic [31:0] rv;

   initial begin
      repeat (300000) @(posedge clk);
      chk(1'b0, "R10 global watchdog expired", 0, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = fill(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_rd(0, 8'h20, rv);
      chk(rv == 0, "R1 tx status after reset", rv, 0);
      chk(!t_busy && !t_irq && !t_rd_req && !t_valid, "R1 tx outputs idle",
          {t_busy, t_irq, t_rd_req, t_valid}, 0);
      reg_rd(1, 8'h20, rv);
      chk(rv == 0, "R1 rx status after reset", rv, 0);
      chk(!r_busy && !r_irq && !r_wr_req && !r_ready, "R1 rx outputs idle",
          {r_busy, r_irq, r_wr_req, r_ready}, 0);

      // R3 pointer registers
      reg_wr(0, 8'h00, 32'h12345678);
      reg_rd(0, 8'h00, rv);
      chk(rv == 32'h12345678, "R3 upper pointer readback", rv, 32'h12345678);
      reg_wr(0, 8'h00, 32'h0);

      // sweep of chain shapes
      for (int n = 1; n <= 3; n++)
         for (int s = 0; s < 4; s++)
            tx_chain(n, s, 'h100);

      // R3 unaligned pointer write is aligned down
      tx_chain(2, 1, 'h105);
      reg_rd(0, 8'h04, rv);
      chk(rv == 32'h100, "R3 lower pointer masked", rv, 32'h100);

      // R9 masking
      put_desc('h100, 8'h23, 8, 32'h400);
      cap_n = 0;
      reg_wr(0, 8'h04, 32'h100);
      wait_idle(0);
      chk(!t_irq, "R9 irq masked when enable clear", t_irq, 0);
      reg_rd(0, 8'h28, rv);
      chk(rv == 0, "R9 pending masked", rv, 0);
      reg_wr(0, 8'h24, 32'h1);
      chk(t_irq, "R9 irq with done enabled", t_irq, 1);
      reg_rd(0, 8'h28, rv);
      chk(rv == 1, "R9 pending shows done", rv, 1);
      reg_wr(0, 8'h20, 32'h1);
      chk(!t_irq, "R8 irq after clear", t_irq, 0);
      reg_rd(0, 8'h20, rv);
      chk(rv == 0, "R8 write-one clear", rv, 0);

      // R7 invalid descriptor alone
      reg_wr(0, 8'h24, 32'h2);
      put_desc('h180, 8'h20, 16, 32'h400);
      cap_n = 0;
      reg_wr(0, 8'h04, 32'h180);
      wait_idle(0);
      chk(cap_n == 0, "R7 no data on invalid entry", 32'(cap_n), 0);
      reg_rd(0, 8'h20, rv);
      chk(rv == 2, "R7 error status", rv, 2);
      chk(t_irq, "R9 irq on error enabled", t_irq, 1);
      reg_wr(0, 8'h20, 32'h3);

      // R7 invalid after one good descriptor
      put_desc('h180, 8'h21, 16, 32'h400);
      put_desc('h188, 8'h22, 16, 32'h480);
      exp_n = 4;
      for (int j = 0; j < 4; j++) expv[j] = mem[('h400 >> 2) + j];
      cap_n = 0;
      reg_wr(0, 8'h04, 32'h180);
      wait_idle(0);
      compare_cap("R7 data before invalid entry");
      reg_rd(0, 8'h20, rv);
      chk(rv == 2, "R7 error without done", rv, 2);
      reg_wr(0, 8'h20, 32'h3);
      reg_wr(0, 8'h24, 32'h0);

      // R10 busy and start while busy
      put_desc('h100, 8'h23, 64, 32'h400);
      put_desc('h200, 8'h23, 16, 32'h500);
      exp_n = 16;
      for (int j = 0; j < 16; j++) expv[j] = mem[('h400 >> 2) + j];
      cap_n = 0;
      hold_ready = 1'b1;
      reg_wr(0, 8'h04, 32'h100);
      repeat (10) @(negedge clk);
      #2;
      chk(t_busy, "R10 busy while waiting for ready", t_busy, 1);
      reg_wr(0, 8'h04, 32'h200);
      reg_rd(0, 8'h04, rv);
      chk(rv == 32'h100, "R10 pointer write ignored while busy", rv, 32'h100);
      hold_ready = 1'b0;
      wait_idle(0);
      compare_cap("R10 only first chain moved");
      repeat (20) @(negedge clk);
      #2;
      chk(!t_busy && cap_n == 16, "R10 no restart after busy write",
          32'(cap_n), 16);
      reg_wr(0, 8'h20, 32'h3);

      // R11 receive chain
      put_desc('h300, 8'h21, 12, 32'h600);
      put_desc('h308, 8'h23, 8, 32'h700);
      reg_wr(1, 8'h04, 32'h300);
      repeat (5) @(negedge clk);
      #2;
      chk(!r_busy, "R11 pointer write alone does not start", r_busy, 0);
      rx_idx = 0;
      rx_gen = 1'b1;
      reg_wr(1, 8'h14, 32'h1);
      wait_idle(1);
      rx_gen = 1'b0;
      for (int j = 0; j < 3; j++)
         chk(mem[('h600 >> 2) + j] == 32'hC0DE0000 + 32'(j), "R11 rx buffer one",
             mem[('h600 >> 2) + j], 32'hC0DE0000 + 32'(j));
      for (int j = 0; j < 2; j++)
         chk(mem[('h700 >> 2) + j] == 32'hC0DE0003 + 32'(j), "R11 rx buffer two",
             mem[('h700 >> 2) + j], 32'hC0DE0003 + 32'(j));
      reg_rd(1, 8'h20, rv);
      chk(rv == 1, "R11 R8 rx done", rv, 1);
      reg_rd(1, 8'h14, rv);
      chk(rv == 0, "R11 run bit cleared at end", rv, 0);
      reg_wr(1, 8'h20, 32'h3);

      // R11 stop mid transfer
      put_desc('h340, 8'h23, 64, 32'h800);
      reg_wr(1, 8'h04, 32'h340);
      reg_wr(1, 8'h14, 32'h1);
      repeat (10) @(negedge clk);
      #2;
      chk(r_busy, "R11 rx busy waiting for stream", r_busy, 1);
      reg_wr(1, 8'h14, 32'h0);
      #2;
      chk(!r_busy, "R11 stop ends run", r_busy, 0);
      reg_rd(1, 8'h20, rv);
      chk(rv == 0, "R11 stop sets no status", rv, 0);
      chk(mem['h800 >> 2] == fill('h800 >> 2), "R11 no write after stop",
          mem['h800 >> 2], fill('h800 >> 2));

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule